// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block runs the local bus cycles of a 16-bit processor in its simple, single-master configuration. A requester presents an address, a read-or-write direction, a memory-or-I/O select, a transfer size (byte or word) and write data. The block then steps the bus through the T-states T1, T2, T3, any number of wait states TW, and T4. Along the way it drives the address latch enable, the read and write strobes, the memory/IO indication, the active-low byte-high enable, and the direction and enable controls of an external data transceiver. It steers write data onto the correct byte lanes and returns read data right-justified.

Each T-state lasts two clocks of `clk`, a first half and a second half. This lets the read strobe start half a T-state after the write strobe would, which gives the address drivers time to release the bus before the addressed device drives it. READY is sampled in the second half of T3 and of each TW, so a slow device stretches the cycle in whole T-states. A request is taken only while the block is idle. The block signals completion with a one-clock pulse in the second half of T4.

Top module: `busCycleSeq`

## Requirements
- R1: After reset, and while no cycle runs, the outputs are at rest: ale=0, rdN=1, wrN=1, denN=1, dataOe=0, dataOut=0, cycDone=0, bheN=1, mio=0, dtr=1, rdData=0.
- R2: A request with reqValid=1 in an idle clock is accepted, and T1 starts on the next clock. Each T-state lasts two clocks. ale is 1 only in the first clock of T1. From T1 to the end of T4, addrOut carries the accepted address and mio carries reqMem (1 = memory, 0 = I/O).
- R3: In a write cycle, wrN is 0 from the first clock of T2 through the last clock of T3 and of every TW, and it is 1 in T4. In a read cycle, wrN stays 1.
- R4: In a read cycle, rdN is 0 from the second clock of T2 through T3 and every TW, and it is 1 in T4. It therefore falls one clock later than wrN would. In a write cycle, rdN stays 1.
- R5: READY (readyIn) is sampled in the second clock of T3 and of each TW. A 0 adds one TW (two clocks), and a 1 moves the cycle to T4. A cycle with n low samples therefore lasts 8+2n clocks from T1 to the end of T4.
- R6: The byte enables follow the size and addrOut[0]. A word at an even address gives bheN=0 with addrOut[0]=0 (both lanes). A byte at an odd address, or a word at an odd address, gives bheN=0 with addrOut[0]=1 (upper lane only). A byte at an even address gives bheN=1 with addrOut[0]=0 (lower lane only). During a strobe, bheN=1 together with addrOut[0]=1 never occurs.
- R7: In a write cycle, dataOe is 1 and dataOut holds steady from the first clock of T2 through the first clock of T4, and both are 0 otherwise. On dataOut, bits 7:0 carry the even byte and bits 15:8 the odd byte. A whole word is driven as given. A byte for the upper lane is taken from reqWData[7:0] and placed on bits 15:8. A byte for the lower lane is placed on bits 7:0. An unused lane is 0.
- R8: In a read cycle, dataIn is captured at the clock edge that enters T4. For a whole word, rdData = dataIn. For the lower lane, rdData = {8'h00, dataIn[7:0]}. For the upper lane, rdData = {8'h00, dataIn[15:8]}. rdData keeps its value until the next read capture.
- R9: During a cycle, dtr is 1 for a write and 0 for a read. denN is 0 while write data is driven (as dataOe) or while rdN is 0, and it is 1 otherwise.
- R10: cycDone is 1 for exactly one clock, the second clock of T4. The next clock is idle, and a request may be accepted in it. A reqValid raised while a cycle runs is ignored and is not kept for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two clocks per T-state |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqMem | input | 1 | 1 = memory, 0 = I/O |
| reqWord | input | 1 | 1 = word transfer, 0 = byte |
| reqAddr | input | ADDR_W (20) | Byte address of the transfer |
| reqWData | input | DATA_W (16) | Write data; a byte is given in bits 7:0 |
| readyIn | input | 1 | Device ready, sampled late in T3/TW |
| dataIn | input | DATA_W (16) | Bus data lanes during a read |
| ale | output | 1 | Address latch enable pulse |
| addrOut | output | ADDR_W (20) | Cycle address |
| mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bheN | output | 1 | Byte-high enable, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| denN | output | 1 | Transceiver enable, active low |
| dataOut | output | DATA_W (16) | Write data lanes |
| dataOe | output | 1 | Write data lanes driven |
| rdData | output | DATA_W (16) | Returned read data, right-justified |
| cycDone | output | 1 | One-clock end-of-cycle pulse |

## Verification
The hardest situation to reach from the ports is a long run of wait states that ends on exactly the right sample. Another is a stray request that arrives mid-cycle and has to vanish without leaving a second cycle behind. The bench drives readyIn from its own model: it counts the low samples the model has seen and raises READY only after a chosen number, so zero, one, two and three wait states each land on a known clock. It also raises reqValid during T1/T2 of one cycle, and it starts a new request in the single idle clock after a done pulse, which exercises both the ignore rule and back-to-back acceptance.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4
  } tState_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic loadReq;    // latch the incoming request
    logic captureRd;  // take dataIn on entry to T4
    logic inCycle;    // a bus cycle is running
    logic driveData;  // write lanes are driven
  } seqCtl_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    readyIn,
  output seqCtl_t ctl,
  output logic    ale,
  output logic    rdN,
  output logic    wrN,
  output logic    dtr,
  output logic    denN,
  output logic    cycDone
);

  tState_e state, nextState;
  logic    half;      // 0 = first clock of a T-state, 1 = second
  logic    isWrite;
  logic    strobeSpan;
  logic    rdActive;
  logic    wrActive;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_T1:        nextState = ST_T2;
      ST_T2:        nextState = ST_T3;
      ST_T3, ST_TW: nextState = readyIn ? ST_T4 : ST_TW;
      ST_T4:        nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      half    <= 1'b0;
      isWrite <= 1'b0;
    end else if (state == ST_IDLE) begin
      half <= 1'b0;
      if (reqValid) begin
        state   <= ST_T1;
        isWrite <= reqWrite;
      end
    end else begin
      half <= ~half;
      if (half) state <= nextState;
    end
  end

  assign strobeSpan = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign wrActive   = isWrite && strobeSpan;
  assign rdActive   = !isWrite && (((state == ST_T2) && half) ||
                                   (state == ST_T3) || (state == ST_TW));

  assign ctl.inCycle   = (state != ST_IDLE);
  assign ctl.loadReq   = (state == ST_IDLE) && reqValid;
  assign ctl.driveData = isWrite && (strobeSpan || ((state == ST_T4) && !half));
  assign ctl.captureRd = !isWrite && half && readyIn &&
                         ((state == ST_T3) || (state == ST_TW));

  assign ale     = (state == ST_T1) && !half;
  assign wrN     = !wrActive;
  assign rdN     = !rdActive;
  assign dtr     = ctl.inCycle ? isWrite : 1'b1;
  assign denN    = !(ctl.driveData || rdActive);
  assign cycDone = (state == ST_T4) && half;

endmodule

// File: rtl/busSeqData.sv
module busSeqData
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqMem,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              mio,
  output logic              bheN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [ADDR_W-1:0] addrQ;
  logic              memQ;
  logic              wordQ;
  logic [DATA_W-1:0] wdQ;
  logic [DATA_W-1:0] rdQ;
  logic              loSel;
  logic              hiSel;
  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] rdSteer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      memQ  <= 1'b0;
      wordQ <= 1'b0;
      wdQ   <= '0;
    end else if (ctl.loadReq) begin
      addrQ <= reqAddr;
      memQ  <= reqMem;
      wordQ <= reqWord;
      wdQ   <= reqWData;
    end
  end

  // lane selection: even byte on the low lane, odd byte on the high lane
  assign loSel = !addrQ[0];
  assign hiSel = wordQ || addrQ[0];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic              laneEn;
    logic [LANE_W-1:0] laneSrc;
    assign laneEn  = (g == 0) ? loSel : hiSel;
    assign laneSrc = ((g == 1) && loSel) ? wdQ[DATA_W-1:LANE_W] : wdQ[LANE_W-1:0];
    assign laneData[g*LANE_W +: LANE_W] = laneEn ? laneSrc : '0;
  end

  always_comb begin
    if (loSel && hiSel)
      rdSteer = dataIn;
    else if (loSel)
      rdSteer = {{LANE_W{1'b0}}, dataIn[LANE_W-1:0]};
    else
      rdSteer = {{LANE_W{1'b0}}, dataIn[DATA_W-1:LANE_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdQ <= '0;
    else if (ctl.captureRd)  rdQ <= rdSteer;
  end

  assign addrOut = addrQ;
  assign mio     = ctl.inCycle && memQ;
  assign bheN    = ctl.inCycle ? !hiSel : 1'b1;
  assign dataOe  = ctl.driveData;
  assign dataOut = ctl.driveData ? laneData : '0;
  assign rdData  = rdQ;

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqMem,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              readyIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ale,
  output logic [ADDR_W-1:0] addrOut,
  output logic              mio,
  output logic              bheN,
  output logic              rdN,
  output logic              wrN,
  output logic              dtr,
  output logic              denN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              cycDone
);

  seqCtl_t ctl;

  busSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .readyIn  (readyIn),
    .ctl      (ctl),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .dtr      (dtr),
    .denN     (denN),
    .cycDone  (cycDone)
  );

  busSeqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqMem   (reqMem),
    .reqWord  (reqWord),
    .reqWData (reqWData),
    .dataIn   (dataIn),
    .addrOut  (addrOut),
    .mio      (mio),
    .bheN     (bheN),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .rdData   (rdData)
  );

endmodule

// File: rtl/busCycleSeqChk.sv
module busCycleSeqChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ale,
  input logic              addr0,
  input logic              bheN,
  input logic              rdN,
  input logic              wrN,
  input logic              denN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              cycDone
);

  // R3/R4: the two strobes are never active together
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R2: address latch enable lasts a single clock
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R3: write strobe opens at the start of T2, two clocks after ale
  p_wr_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> $past(ale, 2));

  // R4: read strobe opens half a T-state later, three clocks after ale
  p_rd_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(ale, 3));

  // R6: the no-transfer combination never appears while a strobe is active
  p_no_empty_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !(bheN && addr0));

  // R7: write lanes hold steady while driven
  p_wdata_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

  // R9: transceiver is enabled whenever a strobe is active
  p_den_cover_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !denN);

  // R10: done is a single-clock pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> !cycDone);

endmodule

bind busCycleSeq busCycleSeqChk #(.DATA_W(DATA_W)) u_busCycleSeqChk (
  .clk     (clk),
  .rstN    (rstN),
  .ale     (ale),
  .addr0   (addrOut[0]),
  .bheN    (bheN),
  .rdN     (rdN),
  .wrN     (wrN),
  .denN    (denN),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .cycDone (cycDone)
);

// File: tb/test_busCycleSeq.sv
`timescale 1ns/1ps
module test_busCycleSeq;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic              reqMem = 1'b0;
  logic              reqWord = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWData = '0;
  logic              readyIn = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              ale, mio, bheN, rdN, wrN, dtr, denN, dataOe, cycDone;
  logic [ADDR_W-1:0] addrOut;
  logic [DATA_W-1:0] dataOut, rdData;

  busCycleSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_busCycleSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMem(reqMem), .reqWord(reqWord), .reqAddr(reqAddr), .reqWData(reqWData),
    .readyIn(readyIn), .dataIn(dataIn), .ale(ale), .addrOut(addrOut),
    .mio(mio), .bheN(bheN), .rdN(rdN), .wrN(wrN), .dtr(dtr), .denN(denN),
    .dataOut(dataOut), .dataOe(dataOe), .rdData(rdData), .cycDone(cycDone)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  bit cmpOn = 0;
  int curWaits = 0;

  // behavioural reference: phase name (0 idle,1 T1,2 T2,3 T3,4 TW,5 T4) and half
  int          mKind = 0;
  int          mHalf = 0;
  int          mLow = 0;
  bit          mW, mMem, mWord;
  logic [19:0] mAddr;
  logic [15:0] mWd;
  logic [15:0] mRd = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mKind = 0; mHalf = 0; mLow = 0; mRd = '0;
    end else if (mKind == 0) begin
      if (reqValid) begin
        mKind = 1; mHalf = 0; mLow = 0;
        mW = reqWrite; mMem = reqMem; mWord = reqWord;
        mAddr = reqAddr; mWd = reqWData;
      end
    end else if (mHalf == 0) begin
      mHalf = 1;
    end else begin
      mHalf = 0;
      if (mKind == 1 || mKind == 2) mKind = mKind + 1;
      else if (mKind == 5) mKind = 0;
      else if (readyIn) begin
        mKind = 5;
        if (!mW) begin
          if (mAddr[0])   mRd = {8'h00, dataIn[15:8]};
          else if (mWord) mRd = dataIn;
          else            mRd = {8'h00, dataIn[7:0]};
        end
      end else begin
        mKind = 4; mLow++;
      end
    end
  end

  always @(negedge clk) readyIn <= (mLow >= curWaits);

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      bit eAle, eWrN, eRdN, eOe, eDen, eDtr, eDone, eMio, eBhe;
      logic [15:0] eOut;
      eAle  = (mKind == 1) && (mHalf == 0);
      eWrN  = !(mW && mKind >= 2 && mKind <= 4);
      eRdN  = !(!mW && mKind != 0 && ((mKind == 2 && mHalf == 1) || mKind == 3 || mKind == 4));
      eOe   = mKind != 0 && mW && ((mKind >= 2 && mKind <= 4) || (mKind == 5 && mHalf == 0));
      eDen  = !(eOe || !eRdN);
      eDtr  = (mKind == 0) ? 1'b1 : mW;
      eDone = (mKind == 5) && (mHalf == 1);
      eMio  = (mKind != 0) && mMem;
      eBhe  = (mKind == 0) ? 1'b1 : !(mWord || mAddr[0]);
      if (!eOe)            eOut = '0;
      else if (mAddr[0])   eOut = {mWd[7:0], 8'h00};
      else if (mWord)      eOut = mWd;
      else                 eOut = {8'h00, mWd[7:0]};
      chk("R2", "ale", ale, eAle);
      chk("R2", "mio", mio, eMio);
      if (mKind != 0) chk("R2", "addrOut", addrOut, mAddr);
      chk("R3", "wrN", wrN, eWrN);
      chk("R4", "rdN", rdN, eRdN);
      chk("R6", "bheN", bheN, eBhe);
      chk("R7", "dataOe", dataOe, eOe);
      chk("R7", "dataOut", dataOut, eOut);
      chk("R8", "rdData", rdData, mRd);
      chk("R9", "dtr", dtr, eDtr);
      chk("R9", "denN", denN, eDen);
      chk("R10", "cycDone", cycDone, eDone);
    end
  end

  // run one bus cycle starting at a negedge, returning at the idle negedge after it
  task automatic doTxn(input bit w, input bit mem, input bit word,
                       input logic [19:0] a, input logic [15:0] wd,
                       input logic [15:0] din, input int nw, input bit stray);
    int n = 0;
    reqWrite = w; reqMem = mem; reqWord = word; reqAddr = a;
    reqWData = wd; dataIn = din; curWaits = nw; reqValid = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) reqValid = 1'b0;
      if (stray && n == 3) reqValid = 1'b1;
      if (stray && n == 5) reqValid = 1'b0;
    end while (!cycDone && n < 100);
    chk("R5", "cycle length", n, 8 + 2 * nw);
    @(negedge clk);
    chk("R10", "idle after done (ale)", ale, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: rest state right after reset
    chk("R1", "ale", ale, 1'b0);
    chk("R1", "rdN", rdN, 1'b1);
    chk("R1", "wrN", wrN, 1'b1);
    chk("R1", "denN", denN, 1'b1);
    chk("R1", "dataOe", dataOe, 1'b0);
    chk("R1", "bheN", bheN, 1'b1);
    chk("R1", "mio", mio, 1'b0);
    chk("R1", "dtr", dtr, 1'b1);
    chk("R1", "rdData", rdData, 16'h0);
    chk("R1", "cycDone", cycDone, 1'b0);
    cmpOn = 1;
    @(negedge clk);
    doTxn(1, 1, 1, 20'h12344, 16'hBEEF, 16'h0000, 0, 0); // memory word write
    doTxn(0, 1, 0, 20'h00031, 16'h0000, 16'hA55A, 2, 0); // odd byte read, 2 waits
    doTxn(1, 0, 0, 20'h00080, 16'h00C3, 16'h0000, 1, 0); // I/O even byte write
    doTxn(0, 0, 1, 20'h00102, 16'h0000, 16'h1357, 0, 0); // I/O word read
    doTxn(0, 1, 1, 20'hFFFF3, 16'h0000, 16'h9ABC, 3, 0); // word at odd address read
    doTxn(0, 1, 0, 20'h40006, 16'h0000, 16'h7E81, 0, 1); // even byte read, stray request
    // R10: stray request ignored, bus stays idle
    repeat (4) begin
      @(negedge clk);
      chk("R10", "no cycle from stray request (ale)", ale, 1'b0);
      chk("R10", "no cycle from stray request (dtr)", dtr, 1'b1);
    end
    doTxn(1, 1, 0, 20'h00011, 16'h005A, 16'h0000, 1, 0); // odd byte write
    doTxn(1, 1, 1, 20'h00200, 16'h2468, 16'h0000, 0, 0); // back-to-back pair
    doTxn(0, 1, 1, 20'h00204, 16'h0000, 16'hCAFE, 1, 0);
    repeat (3) @(negedge clk);
    // R8: read data held after the cycle
    chk("R8", "rdData held", rdData, 16'hCAFE);
    chk("R1", "rest after traffic (rdN)", rdN, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule